// File: doc/BRIEF.md
# Keyed Configuration Port for a Multi-Function I/O Controller

This block is the configuration front end of a multi-function peripheral controller. A host reaches it through two byte ports on a simple I/O bus: an index port at a parameterised base address and a data port one address above it. At reset the block is in run mode, where the configuration registers cannot be reached. Writing an entry key to the index port unlocks configuration mode. In that mode, index-port writes choose a register and data-port accesses read or write that register. An exit key written to the index port locks the block again.

The register space has a global part and a banked part. The global part holds a logical-device select register, a read-only identifier and a read-only revision. The banked part holds one set of registers per logical device: an activate bit and two base-address registers. The select register chooses which set the host sees. Each implemented device drives an enable output and two base-address outputs to its peripheral. Every base value is trimmed by that device's address-decode mask. To program a device, software selects it, clears its activate bit, writes the base and sets the activate bit again.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset the block is in run mode. The index and the device select are 0x00, and every enable and base output is zero.
- R2: In run mode, a write of 0x55 to the index port enters configuration mode. Any other byte written there leaves the block in run mode.
- R3: In configuration mode, a write of 0xAA to the index port returns the block to run mode. Any other byte written there becomes the register index. A read of the index port in configuration mode returns the current index.
- R4: In run mode, data-port writes change no register or output, and reads of either port return 0xFF.
- R5: Register 0x20 reads the DEV_ID parameter (default 0x78) and register 0x21 reads DEV_REV (default 0x01). Writes to either register have no effect.
- R6: Register 0x07 holds the logical-device select. It takes any 8-bit value and reads back what was written.
- R7: Register 0x30 of the selected device holds its activate flag in bit 0 and drives that device's enable output. The other bits read as 0.
- R8: Registers 0x60 (high byte) and 0x61 (low byte) hold base 0 of the selected device. The stored value is masked: 0x07F8 for devices 0, 3, 4 and 5, 0x07FF for device 7, and 0x0780 for device 10. The value appears on that device's 16-bit slice of dev_base0.
- R9: Registers 0x62 (high byte) and 0x63 (low byte) hold base 1. Base 1 is masked with 0x07FF for device 7 and with 0x0000 for every other device.
- R10: Only devices 0, 3, 4, 5, 7 and 10 exist. With an absent or out-of-range device selected, device registers read 0xFF and writes to them change no output. Any unimplemented register index reads 0xFF.
- R11: Bus accesses to addresses other than the two ports change nothing and read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (16) | Host I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address, combinational |
| dev_act | output | LD_COUNT (11) | Enable output per logical device |
| dev_base0 | output | LD_COUNT*16 | Base 0 per device, 16 bits per device, device n at bits [16n+15:16n] |
| dev_base1 | output | LD_COUNT*16 | Base 1 per device, same layout |

## Verification
The checker enforces several properties on every clock cycle. Both key transitions must take effect on the next cycle. The bus must read 0xFF while locked, and no output may move while the block is locked. The identifier read must match the parameter, and an absent device must never show an enable. Other behaviours can only be shown by the bench's scenarios, which drive full sequences and compare all outputs each cycle against a behavioural model. These are the per-device masking, the banking behind the select register, readback of the index and select, and the writes that go to absent devices, unused registers or foreign addresses.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam logic [7:0] KEY_ENTER = 8'h55;
    localparam logic [7:0] KEY_EXIT  = 8'hAA;

    localparam logic [7:0] REG_LDSEL = 8'h07;
    localparam logic [7:0] REG_ID    = 8'h20;
    localparam logic [7:0] REG_REV   = 8'h21;
    localparam logic [7:0] REG_ACT   = 8'h30;
    localparam logic [7:0] REG_B0HI  = 8'h60;
    localparam logic [7:0] REG_B0LO  = 8'h61;
    localparam logic [7:0] REG_B1HI  = 8'h62;
    localparam logic [7:0] REG_B1LO  = 8'h63;

    // Address-decode mask applied to base 0 of a logical device.
    function automatic logic [15:0] base0_mask(input int unsigned ld);
        case (ld)
            7:       return 16'h07FF;
            10:      return 16'h0780;
            default: return 16'h07F8;
        endcase
    endfunction

    // Only the keyboard device has a second base.
    function automatic logic [15:0] base1_mask(input int unsigned ld);
        return (ld == 7) ? 16'h07FF : 16'h0000;
    endfunction

endpackage

// File: rtl/cfgport_keyfsm.sv
module cfgport_keyfsm
    import cfgport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_mode,
    output logic [7:0] index
);

    typedef struct packed {
        logic       cfg;
        logic [7:0] idx;
    } key_st_t;

    key_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (idx_wr) begin
            if (!st_q.cfg) begin
                if (wdata == KEY_ENTER) st_d.cfg = 1'b1;
            end else if (wdata == KEY_EXIT) begin
                st_d.cfg = 1'b0;
            end else begin
                st_d.idx = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_mode = st_q.cfg;
    assign index    = st_q.idx;

endmodule

// File: rtl/cfgport_ldregs.sv
module cfgport_ldregs
    import cfgport_pkg::*;
#(
    parameter logic [15:0] MASK0 = 16'h07F8,
    parameter logic [15:0] MASK1 = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [7:0]  index,
    input  logic [7:0]  wdata,
    output logic        act,
    output logic [15:0] base0,
    output logic [15:0] base1,
    output logic [7:0]  rdata
);

    typedef struct packed {
        logic        act;
        logic [15:0] b0;
        logic [15:0] b1;
    } ld_st_t;

    ld_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (index)
                REG_ACT:  st_d.act      = wdata[0];
                REG_B0HI: st_d.b0[15:8] = wdata & MASK0[15:8];
                REG_B0LO: st_d.b0[7:0]  = wdata & MASK0[7:0];
                REG_B1HI: st_d.b1[15:8] = wdata & MASK1[15:8];
                REG_B1LO: st_d.b1[7:0]  = wdata & MASK1[7:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (index)
            REG_ACT:  rdata = {7'b0, st_q.act};
            REG_B0HI: rdata = st_q.b0[15:8];
            REG_B0LO: rdata = st_q.b0[7:0];
            REG_B1HI: rdata = st_q.b1[15:8];
            REG_B1LO: rdata = st_q.b1[7:0];
            default:  rdata = 8'hFF;
        endcase
    end

    assign act   = st_q.act;
    assign base0 = st_q.b0;
    assign base1 = st_q.b1;

endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
    import cfgport_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CFG_BASE = 16'h002E,
    parameter logic [7:0]  DEV_ID   = 8'h78,
    parameter logic [7:0]  DEV_REV  = 8'h01,
    parameter int unsigned LD_COUNT = 11,
    parameter logic [LD_COUNT-1:0] LD_PRESENT = 11'h4B9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    output logic [LD_COUNT-1:0]    dev_act,
    output logic [LD_COUNT*16-1:0] dev_base0,
    output logic [LD_COUNT*16-1:0] dev_base1
);

    localparam logic [ADDR_W-1:0] DATA_ADDR = CFG_BASE + ADDR_W'(1);

    logic       cfg_mode;
    logic [7:0] index;
    logic       idx_wr, dat_wr;
    logic [7:0] ldsel_d, ldsel_q;
    logic [LD_COUNT-1:0] sel_hit;
    logic [7:0] ld_rdata [LD_COUNT];
    logic [7:0] dev_rd;

    assign idx_wr = bus_wr && (bus_addr == CFG_BASE);
    assign dat_wr = bus_wr && (bus_addr == DATA_ADDR) && cfg_mode;

    cfgport_keyfsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (bus_wdata),
        .cfg_mode (cfg_mode),
        .index    (index)
    );

    always_comb begin
        ldsel_d = ldsel_q;
        if (dat_wr && index == REG_LDSEL) ldsel_d = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ldsel_q <= '0;
        else        ldsel_q <= ldsel_d;
    end

    for (genvar i = 0; i < LD_COUNT; i++) begin : g_ld
        assign sel_hit[i] = (ldsel_q == 8'(i));
        if (LD_PRESENT[i]) begin : g_on
            cfgport_ldregs #(
                .MASK0 (base0_mask(i)),
                .MASK1 (base1_mask(i))
            ) u_regs (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (dat_wr && sel_hit[i]),
                .index (index),
                .wdata (bus_wdata),
                .act   (dev_act[i]),
                .base0 (dev_base0[i*16 +: 16]),
                .base1 (dev_base1[i*16 +: 16]),
                .rdata (ld_rdata[i])
            );
        end else begin : g_off
            assign dev_act[i]            = 1'b0;
            assign dev_base0[i*16 +: 16] = '0;
            assign dev_base1[i*16 +: 16] = '0;
            assign ld_rdata[i]           = 8'hFF;
        end
    end

    always_comb begin
        dev_rd = 8'hFF;
        for (int i = 0; i < LD_COUNT; i++) begin
            if (sel_hit[i]) dev_rd = ld_rdata[i];
        end
    end

    always_comb begin
        bus_rdata = 8'hFF;
        if (cfg_mode) begin
            if (bus_addr == CFG_BASE) begin
                bus_rdata = index;
            end else if (bus_addr == DATA_ADDR) begin
                case (index)
                    REG_LDSEL: bus_rdata = ldsel_q;
                    REG_ID:    bus_rdata = DEV_ID;
                    REG_REV:   bus_rdata = DEV_REV;
                    REG_ACT, REG_B0HI, REG_B0LO,
                    REG_B1HI, REG_B1LO: bus_rdata = dev_rd;
                    default:   bus_rdata = 8'hFF;
                endcase
            end
        end
    end

endmodule

// File: rtl/cfgport_ctrl_chk.sv
module cfgport_ctrl_chk #(
    parameter int unsigned ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CFG_BASE = 16'h002E,
    parameter logic [7:0]  DEV_ID   = 8'h78,
    parameter int unsigned LD_COUNT = 11,
    parameter logic [LD_COUNT-1:0] LD_PRESENT = 11'h4B9
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_wr,
    input logic [7:0]             bus_wdata,
    input logic [7:0]             bus_rdata,
    input logic                   cfg_mode,
    input logic [7:0]             index,
    input logic [LD_COUNT-1:0]    dev_act,
    input logic [LD_COUNT*16-1:0] dev_base0,
    input logic [LD_COUNT*16-1:0] dev_base1
);

    localparam logic [ADDR_W-1:0] DATA_ADDR = CFG_BASE + ADDR_W'(1);

    p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && bus_wr && bus_addr == CFG_BASE && bus_wdata == 8'h55) |=> cfg_mode);

    p_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && bus_wr && bus_addr == CFG_BASE && bus_wdata == 8'hAA) |=> !cfg_mode);

    p_locked_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |-> bus_rdata == 8'hFF);

    p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> ($stable(dev_act) && $stable(dev_base0) && $stable(dev_base1)));

    p_id_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && bus_addr == DATA_ADDR && index == 8'h20) |-> bus_rdata == DEV_ID);

    p_absent_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_act & ~LD_PRESENT) == '0);

endmodule

bind cfgport_ctrl cfgport_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .CFG_BASE   (CFG_BASE),
    .DEV_ID     (DEV_ID),
    .LD_COUNT   (LD_COUNT),
    .LD_PRESENT (LD_PRESENT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_mode  (cfg_mode),
    .index     (index),
    .dev_act   (dev_act),
    .dev_base0 (dev_base0),
    .dev_base1 (dev_base1)
);

// File: tb/cfgport_ctrl_bench.sv
`timescale 1ns/1ps
module cfgport_ctrl_bench;

    localparam int NLD = 11;
    localparam logic [15:0] IDX = 16'h002E;
    localparam logic [15:0] DAT = 16'h002F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [NLD-1:0] dev_act;
    logic [NLD*16-1:0] dev_base0, dev_base1;

    int checks = 0;
    int failures = 0;
    bit live = 1'b0;

    always #2 clk = ~clk;

    cfgport_ctrl u_cfgport_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_act(dev_act),
        .dev_base0(dev_base0), .dev_base1(dev_base1)
    );

    // Behavioural reference model
    bit          m_cfg = 0;
    logic [7:0]  m_idx = 0, m_sel = 0;
    bit          m_act [NLD];
    logic [15:0] m_b0 [NLD];
    logic [15:0] m_b1 [NLD];

    function automatic bit exists(int ld);
        return ld == 0 || ld == 3 || ld == 4 || ld == 5 || ld == 7 || ld == 10;
    endfunction

    function automatic logic [15:0] msk0(int ld);
        if (ld == 7) return 16'h07FF;
        if (ld == 10) return 16'h0780;
        return 16'h07F8;
    endfunction

    function automatic logic [15:0] msk1(int ld);
        return (ld == 7) ? 16'h07FF : 16'h0000;
    endfunction

    function automatic void m_write(logic [15:0] a, logic [7:0] d);
        int s;
        if (a == IDX) begin
            if (!m_cfg) begin
                if (d == 8'h55) m_cfg = 1;
            end else if (d == 8'hAA) m_cfg = 0;
            else m_idx = d;
        end else if (a == DAT && m_cfg) begin
            s = int'(m_sel);
            if (m_idx == 8'h07) m_sel = d;
            else if (s < NLD && exists(s)) begin
                case (m_idx)
                    8'h30: m_act[s] = d[0];
                    8'h60: m_b0[s][15:8] = d & msk0(s)[15:8];
                    8'h61: m_b0[s][7:0]  = d & msk0(s)[7:0];
                    8'h62: m_b1[s][15:8] = d & msk1(s)[15:8];
                    8'h63: m_b1[s][7:0]  = d & msk1(s)[7:0];
                    default: ;
                endcase
            end
        end
    endfunction

    function automatic logic [7:0] m_read(logic [15:0] a);
        int s = int'(m_sel);
        bit ok = (s < NLD) && exists(s);
        if (!m_cfg) return 8'hFF;
        if (a == IDX) return m_idx;
        if (a != DAT) return 8'hFF;
        case (m_idx)
            8'h07: return m_sel;
            8'h20: return 8'h78;
            8'h21: return 8'h01;
            8'h30: return ok ? {7'b0, m_act[s]} : 8'hFF;
            8'h60: return ok ? m_b0[s][15:8] : 8'hFF;
            8'h61: return ok ? m_b0[s][7:0] : 8'hFF;
            8'h62: return ok ? m_b1[s][15:8] : 8'hFF;
            8'h63: return ok ? m_b1[s][7:0] : 8'hFF;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    // Output comparison on every clock (R1 R7 R8 R9)
    always @(negedge clk) begin
        if (live) begin
            for (int ld = 0; ld < NLD; ld++) begin
                checks++;
                if (dev_act[ld] !== m_act[ld] || dev_base0[ld*16 +: 16] !== m_b0[ld]
                    || dev_base1[ld*16 +: 16] !== m_b1[ld]) begin
                    failures++;
                    $display("FAIL R1/R7/R8/R9 dev %0d: got act=%b b0=0x%04h b1=0x%04h expected act=%b b0=0x%04h b1=0x%04h",
                             ld, dev_act[ld], dev_base0[ld*16 +: 16], dev_base1[ld*16 +: 16],
                             m_act[ld], m_b0[ld], m_b1[ld]);
                end
            end
        end
    end

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1;
        m_write(a, d);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, string tag);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        chk(tag, bus_rdata, m_read(a));
    endtask

    task automatic setr(logic [7:0] r, logic [7:0] d);
        wr(IDX, r);
        wr(DAT, d);
    endtask

    task automatic getr(logic [7:0] r, string tag);
        wr(IDX, r);
        rd(DAT, tag);
    endtask

    initial begin
        for (int i = 0; i < NLD; i++) begin
            m_act[i] = 0; m_b0[i] = '0; m_b1[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;

        rd(IDX, "R1");
        rd(DAT, "R1");
        chk("R1", bus_rdata, 8'hFF);

        wr(IDX, 8'h56);
        rd(IDX, "R2");
        wr(DAT, 8'h09);                 // locked write, must not land (R4)
        wr(IDX, 8'h55);
        rd(IDX, "R3");
        chk("R2", bus_rdata, 8'h00);
        getr(8'h07, "R6");
        chk("R4", bus_rdata, 8'h00);

        getr(8'h20, "R5");
        chk("R5", bus_rdata, 8'h78);
        wr(DAT, 8'h00);
        rd(DAT, "R5");
        getr(8'h21, "R5");

        // serial port 1: select, deactivate, base, activate
        setr(8'h07, 8'h04);
        setr(8'h30, 8'h00);
        setr(8'h60, 8'h03);
        setr(8'h61, 8'hFF);
        setr(8'h30, 8'h01);
        getr(8'h60, "R8");
        getr(8'h61, "R8");
        chk("R8", bus_rdata, 8'hF8);
        getr(8'h30, "R7");
        setr(8'h62, 8'h12);
        getr(8'h62, "R9");

        // serial port 2 with a stray high bit in the activate write
        setr(8'h07, 8'h05);
        setr(8'h60, 8'hFA);
        setr(8'h61, 8'hFF);
        setr(8'h30, 8'hFF);
        getr(8'h30, "R7");
        chk("R7", bus_rdata, 8'h01);
        getr(8'h60, "R8");
        getr(8'h07, "R6");

        // keyboard controller with its second base
        setr(8'h07, 8'h07);
        setr(8'h60, 8'h00);
        setr(8'h61, 8'h60);
        setr(8'h62, 8'h00);
        setr(8'h63, 8'h64);
        setr(8'h30, 8'h01);
        getr(8'h63, "R9");
        chk("R9", bus_rdata, 8'h64);

        // runtime block coarse mask
        setr(8'h07, 8'h0A);
        setr(8'h60, 8'hFF);
        setr(8'h61, 8'hFF);
        getr(8'h61, "R8");
        chk("R8", bus_rdata, 8'h80);

        // absent and out-of-range devices, unused register
        setr(8'h07, 8'h01);
        setr(8'h30, 8'h01);
        setr(8'h60, 8'h03);
        getr(8'h30, "R10");
        setr(8'h07, 8'h20);
        setr(8'h30, 8'h01);
        getr(8'h60, "R10");
        getr(8'h40, "R10");

        // foreign address
        wr(16'h0030, 8'h55);
        rd(16'h0030, "R11");
        wr(16'h002D, 8'hAA);
        rd(IDX, "R11");

        // index readback and exit
        wr(IDX, 8'h61);
        rd(IDX, "R3");
        wr(IDX, 8'hAA);
        rd(IDX, "R3");
        wr(IDX, 8'h07);
        wr(DAT, 8'h04);
        rd(DAT, "R4");
        wr(IDX, 8'h30);
        wr(DAT, 8'h00);
        rd(IDX, "R4");
        wr(IDX, 8'h55);
        rd(IDX, "R3");
        getr(8'h07, "R6");
        setr(8'h07, 8'h04);
        getr(8'h30, "R4");

        repeat (4) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule